// File: doc/BRIEF.md
# SPI Client Receive/Transmit Engine

This block is the client side of a 4-wire serial link. An external host drives the serial clock, the data-in line and an active-low select. The block shifts characters of 8 or 9 bits in and out, MSB first. Both edges use the timing with clock idle low and sampling on the rising edge. A received character lands in a single-entry buffer with an overflow flag. Outgoing data comes from a data register. That register is copied into the shift register when select falls. When preload is enabled, a write made while select is high goes straight into the shift register.

The receiver has its own enable. Turning it off takes effect at once. It empties the buffer, clears the overflow flag and throws away any partial character. Turning it on while the serial function is idle takes effect at once. Turning it on while the function is running goes through a short synchronization, and a busy flag stays high until capture starts. A one-cycle wake pulse can be raised on a falling select edge. Preload, character size and wake enable are sampled only while the serial function is off. All serial pins are brought into the system clock domain through two-flop synchronizers before use.

Top module: `spi_client`

## Requirements
- R1: Writing 0 to the receiver enable makes `rxen_rdata` read 0 after the next clock edge. In that same edge `rx_valid` and `rx_ovf` clear and any partly shifted character is discarded.
- R2: Writing 1 to the receiver enable while `spi_en` is 0 makes `rxen_rdata` read 1 after the next edge. `sync_busy` stays 0 and the receiver captures characters once the link runs.
- R3: Writing 1 to the receiver enable while `spi_en` is 1 and the receiver is off makes `rxen_rdata` read 1 and raises `sync_busy` for exactly 2 clocks. After that the receiver captures characters.
- R4: Data is sampled on rising `sck` while `ss_n` is low, MSB first. A completed character sets `rx_valid` with the value on `rx_data`, and a `data_rd` pulse clears `rx_valid`.
- R5: Character size code 1 selects 9-bit characters. Code 0 selects 8-bit characters, and the reserved codes 2 to 7 also give 8 bits. An 8-bit character reads with bit 8 as 0.
- R6: A character completing while `rx_valid` is 1 sets `rx_ovf`. That character is dropped and `rx_data` keeps the earlier one.
- R7: With preload off, a `data_wr` value is copied to the shift register on the falling `ss_n` edge. It appears MSB first on `miso` before each rising `sck`.
- R8: With preload on, a `data_wr` made while `ss_n` is high goes directly to the shift register. Its MSB is on `miso` before `ss_n` falls, and its bits are sent in the next character.
- R9: When wake detection is enabled, each falling `ss_n` edge gives exactly one one-cycle `wake` pulse. When it is disabled, no pulse is given.
- R10: Preload, character size and wake enable are captured only while `spi_en` is 0. Changes made while it is 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_en | input | 1 | Serial function enable; select is treated as high while 0 |
| cfg_preload_en | input | 1 | Preload enable, captured while `spi_en` is 0 |
| cfg_char_size | input | 3 | Character size code, captured while `spi_en` is 0 |
| cfg_ss_wake_en | input | 1 | Wake-on-select-fall enable, captured while `spi_en` is 0 |
| rxen_wr | input | 1 | Receiver enable write strobe |
| rxen_wdata | input | 1 | Receiver enable write value |
| rxen_rdata | output | 1 | Receiver enable read-back |
| sync_busy | output | 1 | Receiver enable synchronization in progress |
| data_wr | input | 1 | Transmit data write strobe |
| data_wdata | input | 9 | Transmit data |
| data_rd | input | 1 | Receive data read strobe; clears `rx_valid` |
| rx_data | output | 9 | Receive buffer contents |
| rx_valid | output | 1 | Receive buffer full |
| rx_ovf | output | 1 | Receive overflow flag |
| wake | output | 1 | One-cycle pulse on falling select |
| sck | input | 1 | Serial clock from host |
| mosi | input | 1 | Serial data from host |
| ss_n | input | 1 | Active-low client select |
| miso | output | 1 | Serial data to host |

## Verification
The assertions assume that the host keeps each `sck` level and each `ss_n` level for several system clocks. This lets the synchronized edges arrive one at a time, and it means select and clock never change in the same cycle. The assertions also assume the configuration inputs change only while `spi_en` is 0. The bench holds every serial level for at least four clocks and changes `mosi` only while `sck` is low. It changes configuration only with `spi_en` low, except in the one check that tests R10.

// File: rtl/spi_client_pkg.sv
package spi_client_pkg;

  localparam int MAX_BITS = 9;
  localparam int CNT_W    = $clog2(MAX_BITS + 1);

  typedef struct packed {
    logic       preload;
    logic [2:0] csize;
    logic       wake_en;
  } spi_cfg_t;

  // code 1 -> 9 bits; 0 and reserved codes -> 8 bits
  function automatic logic [CNT_W-1:0] char_bits(input logic [2:0] code);
    return (code == 3'd1) ? CNT_W'(9) : CNT_W'(8);
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int           N      = 3,
  parameter int           STAGES = 2,
  parameter logic [N-1:0] RSTVAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);

  generate
    for (genvar i = 0; i < N; i++) begin : g_pin
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RSTVAL[i]}};
        else        chain_q <= {chain_q[STAGES-2:0], din[i]};
      end
      assign dout[i] = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/spi_rxen_ctrl.sv
module spi_rxen_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_en,
  input  logic wr,
  input  logic wdata,
  output logic en_bit,
  output logic busy,
  output logic active,
  output logic flush
);

  localparam int CW = (SYNC_STAGES > 1) ? $clog2(SYNC_STAGES) : 1;

  logic          en_q, en_d;
  logic          busy_q, busy_d;
  logic          act_q, act_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    en_d   = en_q;
    busy_d = busy_q;
    act_d  = act_q;
    cnt_d  = cnt_q;
    if (busy_q) begin
      if (cnt_q == CW'(SYNC_STAGES - 1)) begin
        busy_d = 1'b0;
        act_d  = 1'b1;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
    if (wr) begin
      if (!wdata) begin
        en_d   = 1'b0;
        busy_d = 1'b0;
        act_d  = 1'b0;
        cnt_d  = '0;
      end else if (!act_q && !busy_q) begin
        en_d = 1'b1;
        if (spi_en) begin
          busy_d = 1'b1;
          cnt_d  = '0;
        end else begin
          act_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      busy_q <= 1'b0;
      act_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      en_q   <= en_d;
      busy_q <= busy_d;
      act_q  <= act_d;
      cnt_q  <= cnt_d;
    end
  end

  assign en_bit = en_q;
  assign busy   = busy_q;
  assign active = act_q;
  assign flush  = wr & ~wdata;

  assert_busy_reads_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> en_q);
  assert_disable_at_once_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !wdata) |=> (!en_q && !act_q && !busy_q));
  assert_busy_ends_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_q) && en_q) |-> act_q);
  assert_idle_enable_direct_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata && !spi_en && !busy_q) |=> (act_q && !busy_q));

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_client_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sck_s,
  input  logic                mosi_s,
  input  logic                ss_s,
  input  spi_cfg_t            cfg,
  input  logic                rx_active,
  input  logic                flush,
  input  logic                data_wr,
  input  logic [MAX_BITS-1:0] data_wdata,
  input  logic                data_rd,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                rx_valid,
  output logic                rx_ovf,
  output logic                miso,
  output logic                wake
);

  logic                sck_q, ss_q;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [MAX_BITS-1:0] rx_sh_q, rx_sh_d;
  logic [MAX_BITS-1:0] tx_sh_q, tx_sh_d;
  logic [MAX_BITS-1:0] tx_q, tx_d;
  logic [MAX_BITS-1:0] buf_q, buf_d;
  logic                valid_q, valid_d;
  logic                ovf_q, ovf_d;
  logic                wake_q, wake_d;

  logic                sck_rise, sck_fall, ss_fall, ss_low;
  logic [CNT_W-1:0]    nbits;
  logic [MAX_BITS-1:0] rx_next, char_val;

  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;
  assign ss_fall  = ~ss_s & ss_q;
  assign ss_low   = ~ss_s;
  assign nbits    = char_bits(cfg.csize);
  assign rx_next  = {rx_sh_q[MAX_BITS-2:0], mosi_s};
  assign char_val = (nbits == CNT_W'(MAX_BITS)) ? rx_next
                                                : {1'b0, rx_next[MAX_BITS-2:0]};

  always_comb begin
    cnt_d   = cnt_q;
    rx_sh_d = rx_sh_q;
    tx_sh_d = tx_sh_q;
    tx_d    = tx_q;
    buf_d   = buf_q;
    valid_d = valid_q;
    ovf_d   = ovf_q;
    wake_d  = ss_fall & cfg.wake_en;

    if (data_rd) valid_d = 1'b0;

    if (!ss_low) begin
      cnt_d = '0;
    end else if (sck_rise) begin
      rx_sh_d = rx_next;
      if (cnt_q == nbits - CNT_W'(1)) begin
        cnt_d   = '0;
        tx_sh_d = tx_q;
        if (rx_active) begin
          if (valid_d) begin
            ovf_d = 1'b1;
          end else begin
            buf_d   = char_val;
            valid_d = 1'b1;
          end
        end
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end else if (sck_fall && (cnt_q != '0)) begin
      tx_sh_d = tx_sh_q << 1;
    end

    if (ss_fall && !cfg.preload) tx_sh_d = tx_q;

    if (data_wr) begin
      if (cfg.preload && !ss_low) tx_sh_d = data_wdata;
      else                        tx_d    = data_wdata;
    end

    if (flush) begin
      valid_d = 1'b0;
      ovf_d   = 1'b0;
      cnt_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      ss_q    <= 1'b1;
      cnt_q   <= '0;
      rx_sh_q <= '0;
      tx_sh_q <= '0;
      tx_q    <= '0;
      buf_q   <= '0;
      valid_q <= 1'b0;
      ovf_q   <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      sck_q   <= sck_s;
      ss_q    <= ss_s;
      cnt_q   <= cnt_d;
      rx_sh_q <= rx_sh_d;
      tx_sh_q <= tx_sh_d;
      tx_q    <= tx_d;
      buf_q   <= buf_d;
      valid_q <= valid_d;
      ovf_q   <= ovf_d;
      wake_q  <= wake_d;
    end
  end

  assign rx_data  = buf_q;
  assign rx_valid = valid_q;
  assign rx_ovf   = ovf_q;
  assign miso     = tx_sh_q[nbits - CNT_W'(1)];
  assign wake     = wake_q;

  assert_ovf_needs_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(valid_q));
  assert_ovf_keeps_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $stable(buf_q));
  assert_flush_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!valid_q && !ovf_q));
  assert_wake_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> $past(cfg.wake_en));
  assert_wake_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |=> !wake_q);

endmodule

// File: rtl/spi_client.sv
module spi_client
  import spi_client_pkg::*;
#(
  parameter int PIN_STAGES  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                spi_en,
  input  logic                cfg_preload_en,
  input  logic [2:0]          cfg_char_size,
  input  logic                cfg_ss_wake_en,
  input  logic                rxen_wr,
  input  logic                rxen_wdata,
  output logic                rxen_rdata,
  output logic                sync_busy,
  input  logic                data_wr,
  input  logic [MAX_BITS-1:0] data_wdata,
  input  logic                data_rd,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                rx_valid,
  output logic                rx_ovf,
  output logic                wake,
  input  logic                sck,
  input  logic                mosi,
  input  logic                ss_n,
  output logic                miso
);

  spi_cfg_t cfg_q, cfg_d;
  logic     cfg_ld;
  logic     rx_active, flush;
  logic [2:0] pins_raw, pins_s;

  // configuration is only taken while the serial function is off
  assign cfg_ld = ~spi_en;
  always_comb begin
    cfg_d = cfg_q;
    if (cfg_ld) begin
      cfg_d.preload = cfg_preload_en;
      cfg_d.csize   = cfg_char_size;
      cfg_d.wake_en = cfg_ss_wake_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign pins_raw = {ss_n | ~spi_en, mosi, sck};

  spi_pin_sync #(.N(3), .STAGES(PIN_STAGES), .RSTVAL(3'b100)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pins_raw),
    .dout (pins_s)
  );

  spi_rxen_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_rxen (
    .clk   (clk),
    .rst_n (rst_n),
    .spi_en(spi_en),
    .wr    (rxen_wr),
    .wdata (rxen_wdata),
    .en_bit(rxen_rdata),
    .busy  (sync_busy),
    .active(rx_active),
    .flush (flush)
  );

  spi_shift_engine u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck_s     (pins_s[0]),
    .mosi_s    (pins_s[1]),
    .ss_s      (pins_s[2]),
    .cfg       (cfg_q),
    .rx_active (rx_active),
    .flush     (flush),
    .data_wr   (data_wr),
    .data_wdata(data_wdata),
    .data_rd   (data_rd),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .rx_ovf    (rx_ovf),
    .miso      (miso),
    .wake      (wake)
  );

  assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && $past(spi_en)) |-> $stable(cfg_q));
  assert_idle_rx_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_active |-> !rx_valid);

endmodule

// File: tb/spi_client_tb.sv
module spi_client_tb;

  logic       clk, rst_n, spi_en;
  logic       cfg_preload_en, cfg_ss_wake_en;
  logic [2:0] cfg_char_size;
  logic       rxen_wr, rxen_wdata, rxen_rdata, sync_busy;
  logic       data_wr, data_rd;
  logic [8:0] data_wdata, rx_data;
  logic       rx_valid, rx_ovf, wake;
  logic       sck, mosi, ss_n, miso;

  int checks = 0;
  int errors = 0;
  int wake_cnt = 0;
  bit done = 0;

  spi_client u_dut (
    .clk(clk), .rst_n(rst_n), .spi_en(spi_en),
    .cfg_preload_en(cfg_preload_en), .cfg_char_size(cfg_char_size),
    .cfg_ss_wake_en(cfg_ss_wake_en),
    .rxen_wr(rxen_wr), .rxen_wdata(rxen_wdata), .rxen_rdata(rxen_rdata),
    .sync_busy(sync_busy), .data_wr(data_wr), .data_wdata(data_wdata),
    .data_rd(data_rd), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ovf(rx_ovf), .wake(wake), .sck(sck), .mosi(mosi), .ss_n(ss_n),
    .miso(miso)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) if (rst_n && wake) wake_cnt <= wake_cnt + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rxen_write(input logic v);
    @(negedge clk); rxen_wr = 1'b1; rxen_wdata = v;
    @(negedge clk); rxen_wr = 1'b0;
  endtask

  task automatic tx_write(input logic [8:0] v);
    @(negedge clk); data_wr = 1'b1; data_wdata = v;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic rd_pulse();
    @(negedge clk); data_rd = 1'b1;
    @(negedge clk); data_rd = 1'b0;
  endtask

  task automatic set_cfg(input logic pl, input logic [2:0] cs, input logic we);
    @(negedge clk); spi_en = 1'b0;
    cfg_preload_en = pl; cfg_char_size = cs; cfg_ss_wake_en = we;
    clks(2); spi_en = 1'b1; clks(2);
  endtask

  task automatic sel_low();  ss_n = 1'b0; clks(8); endtask
  task automatic sel_high(); clks(4); ss_n = 1'b1; clks(8); endtask

  task automatic shift_bits(input int n, input logic [8:0] val, output logic [8:0] got);
    got = '0;
    for (int i = n - 1; i >= 0; i--) begin
      mosi = val[i];
      clks(4);
      got[i] = miso;
      sck = 1'b1; clks(8);
      sck = 1'b0; clks(4);
    end
    clks(4);
  endtask

  task automatic xfer(input int n, input logic [8:0] val, output logic [8:0] got);
    sel_low(); shift_bits(n, val, got); sel_high();
  endtask

  task automatic t_reset();
    chk("R1 reset rx_valid", rx_valid, 0);
    chk("R6 reset rx_ovf", rx_ovf, 0);
    chk("R2 reset rxen_rdata", rxen_rdata, 0);
    chk("R3 reset sync_busy", sync_busy, 0);
    chk("R9 reset wake", wake, 0);
  endtask

  task automatic t_idle_enable();
    logic [8:0] g;
    @(negedge clk); spi_en = 1'b0;
    rxen_write(1'b1);
    chk("R2 rxen read 1", rxen_rdata, 1);
    chk("R2 no busy", sync_busy, 0);
    clks(1); spi_en = 1'b1; clks(2);
    xfer(8, 9'h0A5, g);
    chk("R4 valid", rx_valid, 1);
    chk("R4 data", rx_data, 9'h0A5);
    rd_pulse();
    chk("R4 read clears valid", rx_valid, 0);
  endtask

  task automatic t_deferred();
    logic [8:0] g;
    rxen_write(1'b0);
    chk("R1 rxen read 0", rxen_rdata, 0);
    rxen_write(1'b1);
    chk("R3 rxen reads 1", rxen_rdata, 1);
    chk("R3 busy cycle 1", sync_busy, 1);
    clks(1);
    chk("R3 busy cycle 2", sync_busy, 1);
    clks(1);
    chk("R3 busy ended", sync_busy, 0);
    xfer(8, 9'h03C, g);
    chk("R3 receives after sync", rx_data, 9'h03C);
    rd_pulse();
  endtask

  task automatic t_sizes();
    logic [8:0] g;
    set_cfg(1'b0, 3'd1, 1'b0);
    xfer(9, 9'h1C3, g);
    chk("R5 nine-bit data", rx_data, 9'h1C3);
    rd_pulse();
    set_cfg(1'b0, 3'd5, 1'b0);
    xfer(8, 9'h05A, g);
    chk("R5 reserved code gives 8 bits valid", rx_valid, 1);
    chk("R5 reserved code gives 8 bits data", rx_data, 9'h05A);
    rd_pulse();
    set_cfg(1'b0, 3'd0, 1'b0);
  endtask

  task automatic t_overflow();
    logic [8:0] g;
    xfer(8, 9'h011, g);
    xfer(8, 9'h022, g);
    chk("R6 overflow set", rx_ovf, 1);
    chk("R6 first char kept", rx_data, 9'h011);
    rxen_write(1'b0);
    chk("R1 flush valid", rx_valid, 0);
    chk("R1 flush ovf", rx_ovf, 0);
    rxen_write(1'b1);
    clks(4);
  endtask

  task automatic t_partial();
    logic [8:0] g;
    sel_low();
    shift_bits(4, 9'h00A, g);
    rxen_write(1'b0);
    rxen_write(1'b1);
    clks(4);
    shift_bits(8, 9'h096, g);
    sel_high();
    chk("R1 partial discarded valid", rx_valid, 1);
    chk("R1 partial discarded data", rx_data, 9'h096);
    rd_pulse();
  endtask

  task automatic t_tx();
    logic [8:0] g;
    tx_write(9'h0C6);
    xfer(8, 9'h000, g);
    chk("R7 miso bits", g[7:0], 8'hC6);
    rd_pulse();
  endtask

  task automatic t_preload();
    logic [8:0] g;
    set_cfg(1'b1, 3'd0, 1'b0);
    tx_write(9'h03B);
    clks(2);
    chk("R8 msb on miso before select", miso, 0);
    xfer(8, 9'h000, g);
    chk("R8 preloaded bits", g[7:0], 8'h3B);
    rd_pulse();
    set_cfg(1'b0, 3'd0, 1'b0);
  endtask

  task automatic t_wake();
    int base;
    set_cfg(1'b0, 3'd0, 1'b1);
    base = wake_cnt;
    sel_low(); sel_high();
    chk("R9 one wake pulse", wake_cnt - base, 1);
    set_cfg(1'b0, 3'd0, 1'b0);
    base = wake_cnt;
    sel_low(); sel_high();
    chk("R9 no wake when disabled", wake_cnt - base, 0);
  endtask

  task automatic t_cfg_frozen();
    logic [8:0] g;
    @(negedge clk); cfg_char_size = 3'd1;
    clks(2);
    xfer(8, 9'h077, g);
    chk("R10 size change ignored valid", rx_valid, 1);
    chk("R10 size change ignored data", rx_data, 9'h077);
    rd_pulse();
    cfg_char_size = 3'd0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; spi_en = 1'b0;
    cfg_preload_en = 1'b0; cfg_char_size = 3'd0; cfg_ss_wake_en = 1'b0;
    rxen_wr = 1'b0; rxen_wdata = 1'b0;
    data_wr = 1'b0; data_wdata = '0; data_rd = 1'b0;
    sck = 1'b0; mosi = 1'b0; ss_n = 1'b1;
    clks(4);
    rst_n = 1'b1;
    clks(2);
    t_reset();
    t_idle_enable();
    t_deferred();
    t_sizes();
    t_overflow();
    t_partial();
    t_tx();
    t_preload();
    t_wake();
    t_cfg_frozen();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule